// File: doc/BRIEF.md
# Indexed Block Register Slave for a Clock-Buffer Controller

This block is a two-wire serial slave that gives a host read and write access to a small bank of 8-bit configuration and identification registers. The two bus lines are sampled in the system clock domain. Each line passes through a synchroniser and a glitch filter, and the slave pulls the data line low through an open-drain enable. The contents of the control, per-output enable and per-output stoppable registers are presented as parallel outputs to the neighbouring clock-control logic.

All accesses are indexed block transfers. A write addresses the slave, gives a starting register index and a byte count, and then supplies that many data bytes to consecutive registers. A read first sets the index with a write-addressed preamble. After a repeated START and the read address, the slave returns the contents of the read-count register, followed by the registers from the index onward, until the host declines a byte with a NACK.

Top module: `smbr_regbank_slave`

## Requirements
- R1: After reset the control byte (index 0) is 0x07, the output-enable byte (index 1) is 0xFF, the stoppable-select byte (index 2) is 0x00, the read-count register (index 6) is 0x07, and the slave does not pull the data line low.
- R2: An address byte of 0xDC (write) or 0xDD (read) is acknowledged by pulling the data line low during the ninth clock. Any other address byte is NACKed, and every later byte is NACKed until the next START.
- R3: A block write is made of 0xDC, an index N and a count X, each acknowledged, followed by data bytes. These are stored into registers N, N+1, … and each is acknowledged. The parallel outputs show index 0 on `ctrl_o`, index 1 on `outen_o` (bit k for output k) and index 2 on `stopsel_o`.
- R4: Data bytes sent after the X counted bytes are NACKed and leave every register unchanged. A count of 0 NACKs the first data byte.
- R5: A block read is made of 0xDC, N, a repeated START and 0xDD. The slave first sends the read-count register, then registers N, N+1, … with the most significant bit first, as long as the host acknowledges. After the host's NACK the slave releases the data line.
- R6: Writing index 6 changes the first byte that every later read returns.
- R7: In index 4, bits 3..0 read 0001 and bits 7..4 read the revision parameter. Index 5 reads the device-ID parameter. Index 3 reads 0x00. Writes to indices 3, 4 and 5 are acknowledged but have no effect, and bits 5..3 of index 0 always read 0.
- R8: A data byte aimed at an index of 7 or above is NACKed and ends the write. Reads at indices of 7 or above return 0x00.
- R9: A STOP or START in the middle of a byte abandons the transfer. Bytes that were completed earlier stay written, and after a START the next byte is decoded as an address.
- R10: A clock pulse of a single system-clock cycle on the clock line is not counted as a bus clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls the data line low |
| ctrl_o | output | 8 | Control byte (index 0) |
| outen_o | output | 8 | Per-output enable byte (index 1) |
| stopsel_o | output | 8 | Per-output stoppable-select byte (index 2) |

## Verification
The hardest situation to reach is a condition that breaks off a byte part-way, after earlier bytes of the same transfer have already been committed. Reaching it takes a host model that can stop after any number of bits and issue STOP or a repeated START from a low clock. The bench does exactly that. It then reads back both the committed register and its untouched neighbour, and it checks that a fresh address byte is acknowledged. A second hard case is a one-cycle glitch on the clock line inside a data bit. The bench injects it while the data line is stable and checks that the stored byte is unchanged. Randomised block writes and reads cover out-of-range indices and counts against a bench register model.

// File: rtl/smbr_pkg.sv
// Package: shared constants, state encodings and register-map helpers
// for the indexed block register slave.
// Assumes an 8-bit register width and a seven-entry bank.
package smbr_pkg;

    localparam int          REG_W      = 8;
    localparam int          NUM_REGS   = 7;
    localparam logic [7:0]  NREG8      = 8'(NUM_REGS);
    localparam logic [7:0]  IDX_CTRL   = 8'd0;
    localparam logic [7:0]  IDX_OUTEN  = 8'd1;
    localparam logic [7:0]  IDX_STOPS  = 8'd2;
    localparam logic [7:0]  IDX_RSVD   = 8'd3;
    localparam logic [7:0]  IDX_IDENT  = 8'd4;
    localparam logic [7:0]  IDX_DEVICE = 8'd5;
    localparam logic [7:0]  IDX_RDCNT  = 8'd6;
    localparam logic [3:0]  VENDOR_NIB = 4'b0001;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_RX,
        LK_RX_ACK,
        LK_TX,
        LK_TX_ACK,
        LK_TX_NEXT
    } link_state_e;

    typedef enum logic [2:0] {
        PH_ADDR,
        PH_INDEX,
        PH_COUNT,
        PH_WDATA,
        PH_RDATA
    } phase_e;

    // Writable-bit mask per register index (zero means read-only / reserved)
    function automatic logic [7:0] reg_wmask(int idx);
        case (idx)
            0:       return 8'hC7;
            1:       return 8'hFF;
            2:       return 8'hFF;
            6:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    // Reset value per writable register index
    function automatic logic [7:0] reg_rstval(int idx);
        case (idx)
            0:       return 8'h07;
            1:       return 8'hFF;
            2:       return 8'h00;
            6:       return 8'h07;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smbr_line_filter.sv
// Line conditioner: synchronises one asynchronous bus line into clk and
// removes pulses shorter than FILT_LEN samples.
// Assumes the idle bus level is high; the output resets high.
module smbr_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    win_q;

    // Metastability chain into the clk domain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end

    // Sample window of the synchronised level
    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '1;
        else        win_q <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
    end

    // Output follows only a level held across the whole window
    always_ff @(posedge clk) begin
        if (!rst_n)          clean_o <= 1'b1;
        else if (&win_q)     clean_o <= 1'b1;
        else if (~|win_q)    clean_o <= 1'b0;
    end

endmodule

// File: rtl/smbr_bus_events.sv
// Bus event detector: turns the filtered clock and data levels into
// single-cycle pulses for clock edges, START and STOP.
// Assumes both inputs are already synchronous and glitch-free.
module smbr_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    // Previous-cycle levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  =  scl_f & ~scl_q;
    assign scl_fall  = ~scl_f &  scl_q;
    assign start_det =  scl_f &  scl_q &  sda_q & ~sda_f;
    assign stop_det  =  scl_f &  scl_q & ~sda_q &  sda_f;

endmodule

// File: rtl/smbr_link_fsm.sv
// Link controller: bit-level receive/transmit and the indexed block
// protocol (address, index, count, data / count-first read).
// Assumes single-cycle event pulses from smbr_bus_events and a
// combinational read port on the register bank.
module smbr_link_fsm
    import smbr_pkg::*;
#(
    parameter logic [6:0] ADDR7 = 7'h6E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_rise,
    input  logic        scl_fall,
    input  logic        start_det,
    input  logic        stop_det,
    input  logic        sda_lvl,
    input  logic [7:0]  rd_data,
    output logic [7:0]  rd_idx,
    output logic        wr_en,
    output logic [7:0]  wr_idx,
    output logic [7:0]  wr_data,
    output logic        sda_low,
    output link_state_e state_o
);

    localparam logic [7:0] WR_ADDR = {ADDR7, 1'b0};
    localparam logic [7:0] RD_ADDR = {ADDR7, 1'b1};

    link_state_e st;
    phase_e      phase;
    logic [7:0]  shreg;
    logic [3:0]  bitcnt;
    logic [7:0]  ptr;
    logic [7:0]  wrem;
    logic        rd_first;

    assign rd_idx  = rd_first ? IDX_RDCNT : ptr;
    assign state_o = st;

    // Protocol sequencing, shifting and open-drain drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= LK_IDLE;
            phase    <= PH_ADDR;
            shreg    <= '0;
            bitcnt   <= '0;
            ptr      <= '0;
            wrem     <= '0;
            rd_first <= 1'b0;
            sda_low  <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                st      <= LK_IDLE;
                sda_low <= 1'b0;
            end else if (start_det) begin
                st       <= LK_RX;
                phase    <= PH_ADDR;
                bitcnt   <= '0;
                rd_first <= 1'b0;
                sda_low  <= 1'b0;
            end else begin
                case (st)
                    LK_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_lvl};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            st     <= LK_RX_ACK;
                            bitcnt <= '0;
                            case (phase)
                                PH_ADDR: begin
                                    if (shreg == WR_ADDR) begin
                                        sda_low <= 1'b1;
                                        phase   <= PH_INDEX;
                                    end else if (shreg == RD_ADDR) begin
                                        sda_low  <= 1'b1;
                                        phase    <= PH_RDATA;
                                        rd_first <= 1'b1;
                                    end else begin
                                        st <= LK_IDLE;
                                    end
                                end
                                PH_INDEX: begin
                                    ptr     <= shreg;
                                    sda_low <= 1'b1;
                                    phase   <= PH_COUNT;
                                end
                                PH_COUNT: begin
                                    wrem    <= shreg;
                                    sda_low <= 1'b1;
                                    phase   <= PH_WDATA;
                                end
                                PH_WDATA: begin
                                    if (wrem != 8'd0 && ptr < NREG8) begin
                                        wr_en   <= 1'b1;
                                        wr_idx  <= ptr;
                                        wr_data <= shreg;
                                        ptr     <= ptr + 8'd1;
                                        wrem    <= wrem - 8'd1;
                                        sda_low <= 1'b1;
                                    end else begin
                                        st <= LK_IDLE;
                                    end
                                end
                                default: st <= LK_IDLE;
                            endcase
                        end
                    end
                    LK_RX_ACK: begin
                        if (scl_fall) begin
                            sda_low <= 1'b0;
                            if (phase == PH_RDATA) begin
                                shreg    <= rd_data;
                                sda_low  <= ~rd_data[7];
                                bitcnt   <= '0;
                                rd_first <= 1'b0;
                                st       <= LK_TX;
                            end else begin
                                st <= LK_RX;
                            end
                        end
                    end
                    LK_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_low <= 1'b0;
                                st      <= LK_TX_ACK;
                            end else begin
                                shreg   <= {shreg[6:0], 1'b0};
                                sda_low <= ~shreg[6];
                                bitcnt  <= bitcnt + 4'd1;
                            end
                        end
                    end
                    LK_TX_ACK: begin
                        if (scl_rise) st <= sda_lvl ? LK_IDLE : LK_TX_NEXT;
                    end
                    LK_TX_NEXT: begin
                        if (scl_fall) begin
                            shreg   <= rd_data;
                            sda_low <= ~rd_data[7];
                            bitcnt  <= '0;
                            ptr     <= ptr + 8'd1;
                            st      <= LK_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/smbr_reg_bank.sv
// Register bank: writable configuration registers with per-bit masks,
// constant identification bytes and a combinational read port.
// Assumes at most one write strobe per cycle from the link controller.
module smbr_reg_bank
    import smbr_pkg::*;
#(
    parameter logic [3:0] REV_ID = 4'h2,
    parameter logic [7:0] DEV_ID = 8'h5B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_idx,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_idx,
    output logic [7:0] rd_data,
    output logic [7:0] ctrl_o,
    output logic [7:0] outen_o,
    output logic [7:0] stopsel_o
);

    localparam logic [7:0] IDENT_BYTE = {REV_ID, VENDOR_NIB};

    logic [REG_W-1:0] cur [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (reg_wmask(g) != 8'h00) begin : g_rw
            localparam logic [7:0] MASK = reg_wmask(g);
            logic [7:0] q;
            // Masked storage of one writable register
            always_ff @(posedge clk) begin
                if (!rst_n)                          q <= reg_rstval(g);
                else if (wr_en && wr_idx == 8'(g))   q <= wr_data & MASK;
            end
            assign cur[g] = q;
        end else if (g == int'(IDX_IDENT)) begin : g_ident
            assign cur[g] = IDENT_BYTE;
        end else if (g == int'(IDX_DEVICE)) begin : g_dev
            assign cur[g] = DEV_ID;
        end else begin : g_zero
            assign cur[g] = 8'h00;
        end
    end

    // Read mux; indices outside the bank return zero
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == 8'(i)) rd_data = cur[i];
        end
    end

    assign ctrl_o    = cur[IDX_CTRL];
    assign outen_o   = cur[IDX_OUTEN];
    assign stopsel_o = cur[IDX_STOPS];

endmodule

// File: rtl/smbr_regbank_slave.sv
// Top: indexed block register slave. Conditions both bus lines,
// detects bus events, runs the link controller and holds the bank.
// Assumes open-drain pads outside; sda_drive_low=1 pulls the line low.
module smbr_regbank_slave
    import smbr_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3,
    parameter logic [6:0] ADDR7       = 7'h6E,
    parameter logic [3:0] REV_ID      = 4'h2,
    parameter logic [7:0] DEV_ID      = 8'h5B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_drive_low,
    output logic [7:0] ctrl_o,
    output logic [7:0] outen_o,
    output logic [7:0] stopsel_o
);

    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0] raw_l;
    logic [NUM_LINES-1:0] clean_l;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] rd_idx, rd_data, wr_idx, wr_data;
    logic wr_en;
    link_state_e link_state;

    assign raw_l = {sda_i, scl_i};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        smbr_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_l[g]),
            .clean_o(clean_l[g])
        );
    end

    smbr_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (clean_l[0]),
        .sda_f    (clean_l[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    smbr_link_fsm #(.ADDR7(ADDR7)) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_lvl  (clean_l[1]),
        .rd_data  (rd_data),
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .sda_low  (sda_drive_low),
        .state_o  (link_state)
    );

    smbr_reg_bank #(.REV_ID(REV_ID), .DEV_ID(DEV_ID)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .ctrl_o   (ctrl_o),
        .outen_o  (outen_o),
        .stopsel_o(stopsel_o)
    );

endmodule

// File: rtl/smbr_slave_chk.sv
// Checker: temporal properties of the register slave, bound to the top.
module smbr_slave_chk
    import smbr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start_det,
    input logic        stop_det,
    input logic        sda_drive_low,
    input logic        wr_en,
    input logic [7:0]  wr_idx,
    input link_state_e link_state,
    input logic [7:0]  ctrl_o,
    input logic [7:0]  outen_o,
    input logic [7:0]  stopsel_o
);

    // R1: reset leaves defaults on the outputs and the line released
    p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_o == 8'h07 && outen_o == 8'hFF &&
                          stopsel_o == 8'h00 && !sda_drive_low));

    // R2: the line is only pulled low while acknowledging or transmitting
    p_drive_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_low |-> (link_state == LK_RX_ACK || link_state == LK_TX));

    // R3: parallel outputs change only after a write strobe
    p_write_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({ctrl_o, outen_o, stopsel_o}));

    // R7: reserved control bits never read as one
    p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[5:3] == 3'b000);

    // R8: no write strobe ever targets an index outside the bank
    p_wr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx < NREG8);

    // R9: a STOP releases the data line on the next cycle
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_drive_low);

    // R9: a START releases the data line on the next cycle
    p_start_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_drive_low);

endmodule

bind smbr_regbank_slave smbr_slave_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .sda_drive_low(sda_drive_low),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .link_state   (link_state),
    .ctrl_o       (ctrl_o),
    .outen_o      (outen_o),
    .stopsel_o    (stopsel_o)
);

// File: tb/smbr_regbank_slave_tb_top.sv
module smbr_regbank_slave_tb_top;

    localparam int         Q      = 6;
    localparam logic [3:0] REV    = 4'h2;
    localparam logic [7:0] DEV    = 8'h5B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic host_low = 1'b0;
    logic sda_drive_low;
    logic [7:0] ctrl_o, outen_o, stopsel_o;
    wire  sda_line = ~(host_low | sda_drive_low);

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] model [7];
    logic [7:0] wbuf [16];

    always #5 clk = ~clk;

    smbr_regbank_slave dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_h),
        .sda_i        (sda_line),
        .sda_drive_low(sda_drive_low),
        .ctrl_o       (ctrl_o),
        .outen_o      (outen_o),
        .stopsel_o    (stopsel_o)
    );

    function automatic logic [7:0] mask_of(int i);
        case (i)
            0: return 8'hC7;
            1, 2, 6: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(int i);
        return (i < 7) ? model[i] : 8'h00;
    endfunction

    task automatic model_reset();
        model[0] = 8'h07; model[1] = 8'hFF; model[2] = 8'h00; model[3] = 8'h00;
        model[4] = {REV, 4'b0001}; model[5] = DEV; model[6] = 8'h07;
    endtask

    task automatic model_write(int i, logic [7:0] d);
        if (i < 7) model[i] = (model[i] & ~mask_of(i)) | (d & mask_of(i));
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        scl_h = 1'b0; wc(Q);
        host_low = 1'b0; wc(Q);
        scl_h = 1'b1; wc(Q);
        host_low = 1'b1; wc(Q);
        scl_h = 1'b0;
    endtask

    task automatic bus_stop();
        scl_h = 1'b0; wc(Q);
        host_low = 1'b1; wc(Q);
        scl_h = 1'b1; wc(Q);
        host_low = 1'b0; wc(Q);
    endtask

    task automatic send_bit(bit b, bit glitch);
        wc(Q);
        host_low = ~b;
        if (glitch) begin
            wc(2); scl_h = 1'b1; wc(1); scl_h = 1'b0; wc(Q - 3);
        end else begin
            wc(Q);
        end
        scl_h = 1'b1; wc(2 * Q);
        scl_h = 1'b0;
    endtask

    task automatic recv_bit(output bit b);
        wc(Q);
        host_low = 1'b0; wc(Q);
        scl_h = 1'b1; wc(Q);
        b = sda_line; wc(Q);
        scl_h = 1'b0;
    endtask

    task automatic write_byte(logic [7:0] v, bit glitch, output bit ack);
        bit r;
        for (int i = 7; i >= 0; i--) send_bit(v[i], glitch && i == 3);
        recv_bit(r);
        ack = ~r;
    endtask

    task automatic send_bits(logic [7:0] v, int n);
        for (int i = 7; i > 7 - n; i--) send_bit(v[i], 1'b0);
    endtask

    task automatic read_byte(bit ack, output logic [7:0] v);
        bit r;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(r);
            v[i] = r;
        end
        send_bit(~ack, 1'b0);
    endtask

    // Block write of nsend bytes from wbuf; acks and model follow the rules
    task automatic blk_write(logic [7:0] n, logic [7:0] x, int nsend, bit glitch, string req);
        bit a;
        bit ea;
        bus_start();
        write_byte(8'hDC, 1'b0, a); chk(a, req, "write address ack", a, 1);
        write_byte(n, 1'b0, a);     chk(a, req, "index ack", a, 1);
        write_byte(x, 1'b0, a);     chk(a, req, "count ack", a, 1);
        for (int k = 0; k < nsend; k++) begin
            ea = (k < int'(x)) && (int'(n) + k < 7);
            write_byte(wbuf[k], glitch, a);
            chk(a == ea, req, "data ack", a, ea);
            if (!ea) break;
            model_write(int'(n) + k, wbuf[k]);
        end
        bus_stop();
    endtask

    // Block read of m data bytes after the count byte
    task automatic blk_read(logic [7:0] n, int m, string req);
        bit a;
        logic [7:0] v;
        bus_start();
        write_byte(8'hDC, 1'b0, a); chk(a, req, "read preamble ack", a, 1);
        write_byte(n, 1'b0, a);     chk(a, req, "read index ack", a, 1);
        bus_start();
        write_byte(8'hDD, 1'b0, a); chk(a, req, "read address ack", a, 1);
        read_byte(1'b1, v);
        chk(v == model[6], req, "count byte", v, model[6]);
        for (int k = 0; k < m; k++) begin
            read_byte(k < m - 1, v);
            chk(v == exp_read(int'(n) + k), req, "read data", v, exp_read(int'(n) + k));
        end
        wc(Q);
        chk(sda_line == 1'b1, "R5", "line released after NACK", sda_line, 1);
        bus_stop();
    endtask

    task automatic chk_outputs(string req);
        chk(ctrl_o == model[0], req, "ctrl_o", ctrl_o, model[0]);
        chk(outen_o == model[1], req, "outen_o", outen_o, model[1]);
        chk(stopsel_o == model[2], req, "stopsel_o", stopsel_o, model[2]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit a;
        void'($urandom(32'd20240611));
        model_reset();
        wc(5);
        rst_n = 1'b1;
        wc(3);

        // R1: reset state
        chk_outputs("R1");
        chk(sda_drive_low == 1'b0, "R1", "line released", sda_drive_low, 0);
        blk_read(8'd4, 2, "R1");  // also R7: identification bytes

        // R2: foreign address NACKed, following bytes ignored until START
        bus_start();
        write_byte(8'hA0, 1'b0, a); chk(!a, "R2", "foreign address nack", a, 0);
        write_byte(8'hDC, 1'b0, a); chk(!a, "R2", "no ack without START", a, 0);
        bus_stop();

        // R3: three-byte write from index 0; R7 masks reserved control bits
        wbuf[0] = 8'hFF; wbuf[1] = 8'h00; wbuf[2] = 8'h5A;
        blk_write(8'd0, 8'd3, 3, 1'b0, "R3");
        wc(2);
        chk_outputs("R3");
        chk(ctrl_o == 8'hC7, "R7", "ctrl reserved bits", ctrl_o, 8'hC7);

        // R4: byte beyond count NACKed and not stored
        wbuf[0] = 8'h81; wbuf[1] = 8'h99;
        blk_write(8'd1, 8'd1, 2, 1'b0, "R4");
        wc(2);
        chk(stopsel_o == 8'h5A, "R4", "reg2 untouched", stopsel_o, 8'h5A);
        chk_outputs("R4");

        // R6: count register drives the first read byte
        wbuf[0] = 8'h03;
        blk_write(8'd6, 8'd1, 1, 1'b0, "R6");
        blk_read(8'd0, 3, "R6");

        // R7: writes to reserved and ID registers have no effect
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
        blk_write(8'd3, 8'd3, 3, 1'b0, "R7");
        blk_read(8'd3, 3, "R7");

        // R8: out-of-range write NACKed, out-of-range reads return zero
        wbuf[0] = 8'h11;
        blk_write(8'd9, 8'd1, 1, 1'b0, "R8");
        blk_read(8'd5, 4, "R8");

        // R9: STOP mid-byte keeps completed bytes
        bus_start();
        write_byte(8'hDC, 1'b0, a); write_byte(8'd1, 1'b0, a); write_byte(8'd3, 1'b0, a);
        write_byte(8'h12, 1'b0, a); chk(a, "R9", "first data ack", a, 1);
        model_write(1, 8'h12);
        send_bits(8'hA5, 4);
        bus_stop();
        wc(2);
        chk_outputs("R9");
        // R9: START mid-byte restarts address decoding
        bus_start();
        write_byte(8'hDC, 1'b0, a);
        send_bits(8'h02, 3);
        bus_start();
        write_byte(8'hDC, 1'b0, a); chk(a, "R9", "address after restart ack", a, 1);
        write_byte(8'd2, 1'b0, a); write_byte(8'd1, 1'b0, a);
        write_byte(8'h66, 1'b0, a); chk(a, "R9", "data after restart ack", a, 1);
        model_write(2, 8'h66);
        bus_stop();
        wc(2);
        chk_outputs("R9");

        // R10: one-cycle clock glitch inside a data bit is ignored
        wbuf[0] = 8'h3C;
        blk_write(8'd2, 8'd1, 1, 1'b1, "R10");
        wc(2);
        chk(stopsel_o == 8'h3C, "R10", "glitched byte stored", stopsel_o, 8'h3C);

        // R3/R5/R8: random block writes followed by read-back
        for (int it = 0; it < 18; it++) begin
            logic [7:0] n;
            logic [7:0] x;
            n = 8'($urandom_range(0, 8));
            x = 8'($urandom_range(0, 4));
            for (int k = 0; k < 16; k++) wbuf[k] = 8'($urandom);
            blk_write(n, x, int'(x), 1'b0, "R3");
            wc(2);
            chk_outputs("R3");
            blk_read(8'($urandom_range(0, 8)), $urandom_range(1, 4), "R5");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule